// File: doc/BRIEF.md
# Video Input Automatic Gain Controller

This block closes the gain loop around the analog programmable-gain stage in front of a composite video ADC. It watches the digitised samples, the ADC overflow flag and two per-line timing strobes (one marking the black-level sampling window after the clamp, one marking the sync-tip window). Once per line, at a line strobe, it moves a 0 to 16 gain code by at most one step. Larger codes select more analog gain.

A 2-bit mode input chooses the behaviour. In sync-height mode the loop regulates the measured sync depth (black level minus sync-tip level) towards a target. The default target is 96 codes, which is the sync depth that goes with a 224-step black-to-white range. In overflow-only mode the code starts at its maximum and is only ever lowered: one step for any line in which the ADC overflowed. The search is re-armed by a channel-change pulse or a manual restart pulse. A third mode forces the gain from a fixed-value input. A fourth mode uses sync-height control but lets an overflow in the line override it with a down step.

Top module: `video_agc`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, the gain code reads 16 (the maximum).
- R2: Sync height is the sample captured during the last clamp-window strobe minus the sample captured during the last sync-tip strobe, or 0 if that difference is negative. In mode 0 (sync height), a line strobe with height above target+2 lowers the gain by one in the next cycle.
- R3: In mode 0, a line strobe with height below target-2 raises the gain by one.
- R4: In mode 0, a height within target-2 to target+2 inclusive leaves the gain unchanged.
- R5: The gain never goes below 0 or above 16. A step past either limit holds the code at the limit.
- R6: In mode 1 (overflow only), a line strobe lowers the gain by exactly one if the overflow flag was high in any cycle since the previous line strobe, however many times. Otherwise the gain holds, and sync height has no effect. The gain never rises in this mode.
- R7: In modes 0, 1 and 3, a channel-change pulse sets the gain to 16 in the next cycle.
- R8: In modes 0, 1 and 3, a manual restart pulse sets the gain to 16 in the next cycle.
- R9: In mode 2 (fixed), the gain equals the fixed-gain input (saturated at 16) one cycle later. Restart pulses have no effect in this mode.
- R10: In mode 3 (sync with overflow override), a line with any overflow lowers the gain by one. Otherwise the mode 0 rules apply.
- R11: In mode 0, the overflow flag has no effect on the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 sync height, 1 overflow only, 2 fixed, 3 sync with overflow override |
| adc_data | input | DATA_W | ADC sample |
| adc_ovf | input | 1 | ADC overflow flag |
| clamp_win | input | 1 | High on the sample taken as black level |
| tip_win | input | 1 | High on the sample taken as sync-tip level |
| line_strb | input | 1 | One-cycle pulse per line; gain updates here |
| chan_chg | input | 1 | Channel-change pulse; restarts the search |
| man_restart | input | 1 | Manual restart pulse |
| fixed_gain | input | GAIN_W | Gain code used in mode 2 |
| gain | output | GAIN_W | Gain code to the analog stage |

## Verification
The bench builds the block with its defaults: 10-bit samples, a 96-code sync target with a dead band of two, and a gain ceiling of 16. This keeps the band edges at 94 and 98 reachable with small sample values. Sixteen overflow lines are enough to walk the code from the ceiling to the floor, so both saturation limits are hit in one short run. The two-stage reset synchroniser lets the bench test asynchronous assertion in the middle of a run.

// File: rtl/video_agc_pkg.sv
package video_agc_pkg;
  typedef enum logic [1:0] {
    AGC_SYNC     = 2'd0,
    AGC_OVF      = 2'd1,
    AGC_FIXED    = 2'd2,
    AGC_SYNC_OVF = 2'd3
  } agc_mode_e;
endpackage

// File: rtl/video_agc_rst_sync.sv
module video_agc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/video_agc_meas.sv
module video_agc_meas #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_ovf,
  input  logic              clamp_win,
  input  logic              tip_win,
  input  logic              line_strb,
  input  logic              restart,
  output logic [DATA_W-1:0] height,
  output logic              ovf_line
);
  logic [DATA_W-1:0] black_q, black_d;
  logic [DATA_W-1:0] tip_q, tip_d;
  logic              pend_q, pend_d;

  always_comb begin
    black_d = black_q;
    tip_d   = tip_q;
    if (clamp_win) black_d = adc_data;
    if (tip_win)   tip_d   = adc_data;
    if (line_strb || restart) pend_d = 1'b0;
    else                      pend_d = pend_q | adc_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      black_q <= '0;
      tip_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      black_q <= black_d;
      tip_q   <= tip_d;
      pend_q  <= pend_d;
    end
  end

  assign height   = (black_q > tip_q) ? (black_q - tip_q) : '0;
  assign ovf_line = pend_q | adc_ovf;
endmodule

// File: rtl/video_agc_step.sv
module video_agc_step
  import video_agc_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int GAIN_W      = 5,
  parameter int GAIN_MAX    = 16,
  parameter int SYNC_TARGET = 96,
  parameter int DEADBAND    = 2
) (
  input  agc_mode_e         mode,
  input  logic [GAIN_W-1:0] gain_q,
  input  logic [GAIN_W-1:0] fixed_gain,
  input  logic [DATA_W-1:0] height,
  input  logic              ovf_line,
  input  logic              line_strb,
  input  logic              restart,
  output logic [GAIN_W-1:0] gain_d
);
  localparam logic [GAIN_W-1:0] MAXG = GAIN_W'(GAIN_MAX);
  localparam logic [DATA_W-1:0] LO   = DATA_W'(SYNC_TARGET - DEADBAND);
  localparam logic [DATA_W-1:0] HI   = DATA_W'(SYNC_TARGET + DEADBAND);

  logic [GAIN_W-1:0] dec_v, inc_v;
  logic              too_small, too_big;

  always_comb begin
    dec_v     = (gain_q != '0)  ? gain_q - 1'b1 : gain_q;
    inc_v     = (gain_q < MAXG) ? gain_q + 1'b1 : MAXG;
    too_small = height < LO;
    too_big   = height > HI;
    gain_d    = gain_q;
    if (mode == AGC_FIXED) begin
      gain_d = (fixed_gain > MAXG) ? MAXG : fixed_gain;
    end else if (restart) begin
      gain_d = MAXG;
    end else if (line_strb) begin
      case (mode)
        AGC_SYNC: begin
          if (too_big)        gain_d = dec_v;
          else if (too_small) gain_d = inc_v;
        end
        AGC_OVF: begin
          if (ovf_line) gain_d = dec_v;
        end
        AGC_SYNC_OVF: begin
          if (ovf_line || too_big) gain_d = dec_v;
          else if (too_small)      gain_d = inc_v;
        end
        default: gain_d = gain_q;
      endcase
    end
  end
endmodule

// File: rtl/video_agc.sv
module video_agc
  import video_agc_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int GAIN_MAX    = 16,
  parameter int GAIN_W      = $clog2(GAIN_MAX + 1),
  parameter int SYNC_TARGET = 96,
  parameter int DEADBAND    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_ovf,
  input  logic              clamp_win,
  input  logic              tip_win,
  input  logic              line_strb,
  input  logic              chan_chg,
  input  logic              man_restart,
  input  logic [GAIN_W-1:0] fixed_gain,
  output logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] MAXG = GAIN_W'(GAIN_MAX);

  logic              rst_n_s;
  logic              restart;
  logic [DATA_W-1:0] height;
  logic              ovf_line;
  logic [GAIN_W-1:0] gain_q, gain_d;
  agc_mode_e         mode_e;

  assign restart = chan_chg | man_restart;
  assign mode_e  = agc_mode_e'(mode);

  video_agc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  video_agc_meas #(.DATA_W(DATA_W)) u_meas (
    .clk(clk), .rst_n(rst_n_s), .adc_data(adc_data), .adc_ovf(adc_ovf),
    .clamp_win(clamp_win), .tip_win(tip_win), .line_strb(line_strb),
    .restart(restart), .height(height), .ovf_line(ovf_line)
  );

  video_agc_step #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX),
    .SYNC_TARGET(SYNC_TARGET), .DEADBAND(DEADBAND)
  ) u_step (
    .mode(mode_e), .gain_q(gain_q), .fixed_gain(fixed_gain), .height(height),
    .ovf_line(ovf_line), .line_strb(line_strb), .restart(restart),
    .gain_d(gain_d)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) gain_q <= MAXG;
    else          gain_q <= gain_d;
  end

  assign gain = gain_q;
endmodule

// File: rtl/video_agc_chk.sv
module video_agc_chk #(
  parameter int GAIN_W   = 5,
  parameter int GAIN_MAX = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              line_strb,
  input logic              chan_chg,
  input logic              man_restart,
  input logic [GAIN_W-1:0] fixed_gain,
  input logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] MAXG = GAIN_W'(GAIN_MAX);

  // R5
  gain_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= MAXG);

  // R6
  ovf_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !chan_chg && !man_restart) |=> gain <= $past(gain));

  // R7
  chan_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_chg && mode != 2'd2) |=> gain == MAXG);

  // R8
  man_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (man_restart && mode != 2'd2) |=> gain == MAXG);

  // R9
  fixed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && fixed_gain <= MAXG) |=> gain == $past(fixed_gain));

  // R2
  hold_between_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && !line_strb && !chan_chg && !man_restart) |=> $stable(gain));
endmodule

bind video_agc video_agc_chk #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .mode(mode), .line_strb(line_strb),
  .chan_chg(chan_chg), .man_restart(man_restart), .fixed_gain(fixed_gain),
  .gain(gain)
);

// File: tb/video_agc_test.sv
module video_agc_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [9:0] adc_data;
  logic       adc_ovf, clamp_win, tip_win, line_strb, chan_chg, man_restart;
  logic [4:0] fixed_gain;
  logic [4:0] gain;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  video_agc uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .adc_data(adc_data),
    .adc_ovf(adc_ovf), .clamp_win(clamp_win), .tip_win(tip_win),
    .line_strb(line_strb), .chan_chg(chan_chg), .man_restart(man_restart),
    .fixed_gain(fixed_gain), .gain(gain)
  );

  typedef struct packed {
    logic [1:0] m;
    logic [9:0] black;
    logic [9:0] tip;
    logic [3:0] novf;
    logic [4:0] exp;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{2'd0, 10'd200, 10'd100, 4'd0, 5'd15},
    '{2'd0, 10'd200, 10'd100, 4'd0, 5'd14},
    '{2'd0, 10'd200, 10'd102, 4'd0, 5'd14},
    '{2'd0, 10'd200, 10'd106, 4'd0, 5'd14},
    '{2'd0, 10'd200, 10'd107, 4'd0, 5'd15},
    '{2'd0, 10'd200, 10'd150, 4'd3, 5'd16},
    '{2'd0, 10'd200, 10'd150, 4'd0, 5'd16},
    '{2'd1, 10'd250, 10'd50,  4'd0, 5'd16},
    '{2'd1, 10'd250, 10'd50,  4'd5, 5'd15},
    '{2'd1, 10'd250, 10'd50,  4'd1, 5'd14},
    '{2'd1, 10'd200, 10'd190, 4'd0, 5'd14},
    '{2'd3, 10'd200, 10'd190, 4'd0, 5'd15},
    '{2'd3, 10'd200, 10'd190, 4'd2, 5'd14},
    '{2'd3, 10'd200, 10'd80,  4'd0, 5'd13}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1:       return "R2";
      2, 3:       return "R4";
      4:          return "R3";
      5:          return "R11";
      6:          return "R5";
      7, 8, 9, 10: return "R6";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gain=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_line(input logic [1:0] m, input logic [9:0] b,
                          input logic [9:0] t, input int nov);
    @(negedge clk); mode = m; clamp_win = 1'b1; adc_data = b;
    @(negedge clk); clamp_win = 1'b0; tip_win = 1'b1; adc_data = t;
    @(negedge clk); tip_win = 1'b0; adc_data = 10'd512;
    for (int k = 0; k < nov; k++) begin
      adc_ovf = 1'b1;
      @(negedge clk);
    end
    adc_ovf = 1'b0; line_strb = 1'b1;
    @(negedge clk); line_strb = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; adc_data = '0; adc_ovf = 1'b0;
    clamp_win = 1'b0; tip_win = 1'b0; line_strb = 1'b0;
    chan_chg = 1'b0; man_restart = 1'b0; fixed_gain = 5'd0;
    repeat (3) @(negedge clk);
    check("R1 in reset", gain, 5'd16);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", gain, 5'd16);

    for (int i = 0; i < 14; i++) begin
      run_line(VEC[i].m, VEC[i].black, VEC[i].tip, int'(VEC[i].novf));
      check(vec_req(i), gain, VEC[i].exp);
    end

    // R7: channel change re-arms at maximum
    @(negedge clk); mode = 2'd1; chan_chg = 1'b1;
    @(negedge clk); chan_chg = 1'b0;
    check("R7", gain, 5'd16);

    // R8: manual restart after lowering
    for (int i = 0; i < 3; i++) run_line(2'd1, 10'd200, 10'd100, 2);
    check("R6 three lines", gain, 5'd13);
    @(negedge clk); man_restart = 1'b1;
    @(negedge clk); man_restart = 1'b0;
    check("R8", gain, 5'd16);

    // R5: floor saturation in overflow mode
    for (int i = 0; i < 18; i++) run_line(2'd1, 10'd200, 10'd100, 1);
    check("R5 floor", gain, 5'd0);
    run_line(2'd3, 10'd200, 10'd100, 1);
    check("R5 floor mode3", gain, 5'd0);

    // R9: fixed mode
    @(negedge clk); mode = 2'd2; fixed_gain = 5'd7;
    @(negedge clk);
    check("R9 fixed 7", gain, 5'd7);
    fixed_gain = 5'd25;
    @(negedge clk);
    check("R9 clamp", gain, 5'd16);
    fixed_gain = 5'd3;
    @(negedge clk); chan_chg = 1'b1; man_restart = 1'b1;
    @(negedge clk); chan_chg = 1'b0; man_restart = 1'b0;
    @(negedge clk);
    check("R9 restart ignored", gain, 5'd3);

    // R3: leaving fixed mode, sync loop climbs from the fixed value
    run_line(2'd0, 10'd200, 10'd150, 0);
    check("R3 from fixed", gain, 5'd4);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #2 check("R1 async", gain, 5'd16);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post", gain, 5'd16);

    done = 1'b1;
    finish_run();
  end
endmodule